// File: doc/BRIEF.md
# General-purpose register file with same-cycle write visibility

This block stores the architectural integer registers of a five-stage in-order pipeline. It has 32 entries. Each entry is `DATA_W` bits wide, either 32 or 64. The decode stage reads two source operands through two independent combinational read ports. The write-back stage commits one result per cycle through a single synchronous write port. The caller picks between the ALU result and the load data before the write port, so the block sees only one value and one enable.

A result can be written to a register in the same cycle that a later instruction in decode reads that register. In that case the read port returns the value being written, as if the write happened in the first half of the cycle and the read in the second half. An internal bypass path gives this behaviour, so write-back and decode never have to stall each other over the file. The block does not resolve a second write in the same cycle: the single write port is the only path into the file.

The parameter `ZERO_R0` selects whether register 0 is a constant zero or an ordinary register. Reset is active-low and asynchronous. The caller releases it in step with the clock.

Top module: `gpr_bypass_file`

## Requirements
- R1: The file holds 32 independent entries of `DATA_W` bits. For any mix of writes and reads, each read port returns the most recent value written to the selected entry.
- R2: While `rst_n` is low, and after it is released, every entry reads as zero until it is written.
- R3: When `wr_en` is high at a rising clock edge, `wr_data` is stored into entry `wr_idx`. The value is visible on both read ports from the next cycle on.
- R4: When `wr_en` is low, no entry changes. A read of the entry named by `wr_idx` returns the stored value and not `wr_data`.
- R5: When `wr_en` is high and `wr_idx` equals a port's read index, that port returns `wr_data` in the same cycle, before the clock edge.
- R6: The two read ports are independent. They may select different entries or the same entry in one cycle, and either may be the one that sees the bypass.
- R7: With `ZERO_R0` = 1, reading index 0 returns zero on both ports. A write to index 0 is discarded and is not bypassed.
- R8: With `ZERO_R0` = 0, index 0 behaves like every other entry, including storage and bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears every entry |
| wr_en | input | 1 | Commit `wr_data` to entry `wr_idx` at the next rising edge |
| wr_idx | input | 5 | Destination entry index |
| wr_data | input | DATA_W | Value to commit (already selected between ALU and load result) |
| rd_a_idx | input | 5 | First source entry index |
| rd_a_data | output | DATA_W | First source operand, combinational |
| rd_b_idx | input | 5 | Second source entry index |
| rd_b_data | output | DATA_W | Second source operand, combinational |

## Verification
A corrupted or missing stored entry stays hidden until some port selects that index. From then on the wrong value appears on that port in the same cycle, with no added latency, because the read path has no register. A broken bypass shows only in the cycle where a write and a read name the same index. A wrong write decode shows one cycle after the write, as a stale value or as a changed neighbouring entry. The bench therefore reads back every index after reset, after writes and around index 0. It also pairs each write with same-index and neighbouring reads on both ports. Both settings of the zero-register option are built.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned GPR_DEPTH = 32;
  localparam int unsigned GPR_IDX_W = $clog2(GPR_DEPTH);

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_BYPASS = 2'd1,
    SRC_ZERO   = 2'd2
  } rd_src_e;
endpackage

// File: rtl/gpr_store.sv
module gpr_store #(
  parameter int unsigned DEPTH   = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IDX_W   = 5,
  parameter bit          ZERO_R0 = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [DEPTH-1:0][DATA_W-1:0]  entries
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    if (ZERO_R0 && g == 0) begin : g_const
      assign entries[g] = '0;
    end else begin : g_reg
      logic              hit;
      logic [DATA_W-1:0] cur_q;
      logic [DATA_W-1:0] nxt_d;

      always_comb begin
        hit   = wr_en && (wr_idx == IDX_W'(g));
        nxt_d = hit ? wr_data : cur_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cur_q <= '0;
        end else if (hit) begin
          cur_q <= nxt_d;
        end
      end

      assign entries[g] = cur_q;
    end
  end

endmodule

// File: rtl/gpr_rdport.sv
module gpr_rdport
  import gpr_pkg::*;
#(
  parameter int unsigned DEPTH   = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IDX_W   = 5,
  parameter bit          ZERO_R0 = 1'b1
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] entries,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [DATA_W-1:0]            rd_data
);

  rd_src_e src;

  always_comb begin
    if (ZERO_R0 && (rd_idx == '0)) begin
      src = SRC_ZERO;
    end else if (wr_en && (wr_idx == rd_idx)) begin
      src = SRC_BYPASS;
    end else begin
      src = SRC_ARRAY;
    end
  end

  always_comb begin
    case (src)
      SRC_ZERO:   rd_data = '0;
      SRC_BYPASS: rd_data = wr_data;
      default:    rd_data = entries[rd_idx];
    endcase
  end

endmodule

// File: rtl/gpr_bypass_file.sv
module gpr_bypass_file #(
  parameter int unsigned DATA_W  = 32,
  parameter bit          ZERO_R0 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [4:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [4:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [4:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data
);

  localparam int unsigned DEPTH   = gpr_pkg::GPR_DEPTH;
  localparam int unsigned IDX_W   = gpr_pkg::GPR_IDX_W;
  localparam int unsigned N_PORTS = 2;

  logic [DEPTH-1:0][DATA_W-1:0] entries;
  logic [N_PORTS-1:0][IDX_W-1:0]  port_idx;
  logic [N_PORTS-1:0][DATA_W-1:0] port_data;

  assign port_idx[0] = rd_a_idx;
  assign port_idx[1] = rd_b_idx;
  assign rd_a_data   = port_data[0];
  assign rd_b_data   = port_data[1];

  gpr_store #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .ZERO_R0(ZERO_R0)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .entries(entries)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    gpr_rdport #(
      .DEPTH  (DEPTH),
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W),
      .ZERO_R0(ZERO_R0)
    ) u_rd (
      .entries(entries),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_data(wr_data),
      .rd_idx (port_idx[p]),
      .rd_data(port_data[p])
    );
  end

endmodule

// File: rtl/gpr_bypass_file_chk.sv
module gpr_bypass_file_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter bit          ZERO_R0 = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [4:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [4:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [4:0]        rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_BYPASS_PORT_A: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == rd_a_idx && !(ZERO_R0 && rd_a_idx == 5'd0)) |-> rd_a_data == wr_data); // R5

  AST_BYPASS_PORT_B: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == rd_b_idx && !(ZERO_R0 && rd_b_idx == 5'd0)) |-> rd_b_data == wr_data); // R6

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(wr_en) && $past(wr_idx) == rd_a_idx && !(wr_en && wr_idx == rd_a_idx)
     && !(ZERO_R0 && rd_a_idx == 5'd0)) |-> rd_a_data == $past(wr_data)); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(wr_en) && !wr_en && $stable(rd_b_idx)) |-> $stable(rd_b_data)); // R4

  AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ZERO_R0 && rd_a_idx == 5'd0) |-> rd_a_data == '0); // R7

  AST_ZERO_REG_B: assert property (@(posedge clk) disable iff (!rst_n)
    (ZERO_R0 && rd_b_idx == 5'd0) |-> rd_b_data == '0); // R7

endmodule

bind gpr_bypass_file gpr_bypass_file_chk #(
  .DATA_W (DATA_W),
  .ZERO_R0(ZERO_R0)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .wr_data  (wr_data),
  .rd_a_idx (rd_a_idx),
  .rd_a_data(rd_a_data),
  .rd_b_idx (rd_b_idx),
  .rd_b_data(rd_b_data)
);

// File: tb/sim_gpr_bypass_file.sv
`timescale 1ns/1ps
module sim_gpr_bypass_file;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [63:0] wr_data;
  logic [4:0]  ra, rb;
  logic [31:0] a0, b0;
  logic [63:0] a1, b1;

  gpr_bypass_file #(.DATA_W(32), .ZERO_R0(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data[31:0]), .rd_a_idx(ra), .rd_a_data(a0),
    .rd_b_idx(rb), .rd_b_data(b0));

  gpr_bypass_file #(.DATA_W(64), .ZERO_R0(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_a_idx(ra), .rd_a_data(a1),
    .rd_b_idx(rb), .rd_b_data(b1));

  typedef struct {
    string       tag;
    int          sel;
    logic [63:0] exp;
  } item_t;

  item_t       sb[$];
  logic [31:0] m0[32];
  logic [63:0] m1[32];
  int          total = 0;
  int          bad   = 0;
  bit          done  = 1'b0;

  function automatic logic [63:0] exp_zero(input logic we, input logic [4:0] wi,
                                           input logic [63:0] wd, input logic [4:0] ix);
    if (ix == 5'd0)             return 64'd0;
    else if (we && wi == ix)    return {32'd0, wd[31:0]};
    else                        return {32'd0, m0[ix]};
  endfunction

  function automatic logic [63:0] exp_plain(input logic we, input logic [4:0] wi,
                                            input logic [63:0] wd, input logic [4:0] ix);
    if (we && wi == ix) return wd;
    else                return m1[ix];
  endfunction

  task automatic push(input string tag, input int sel, input logic [63:0] exp);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic cyc(input logic we, input logic [4:0] wi, input logic [63:0] wd,
                     input logic [4:0] ia, input logic [4:0] ib, input string tag);
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_data = wd; ra = ia; rb = ib;
    push(tag, 0, exp_zero(we, wi, wd, ia));
    push(tag, 1, exp_zero(we, wi, wd, ib));
    push(tag, 2, exp_plain(we, wi, wd, ia));
    push(tag, 3, exp_plain(we, wi, wd, ib));
    @(posedge clk);
    if (we) begin
      if (wi != 5'd0) m0[wi] = wd[31:0];
      m1[wi] = wd;
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 32; i++) begin
      m0[i] = '0;
      m1[i] = '0;
    end
  endtask

  // monitor: compares queued expectations well before the next rising edge
  initial begin : monitor
    item_t       it;
    logic [63:0] act;
    forever begin
      @(negedge clk);
      #5;
      while (sb.size() > 0) begin
        it = sb.pop_front();
        case (it.sel)
          0: act = {32'd0, a0};
          1: act = {32'd0, b0};
          2: act = a1;
          default: act = b1;
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s port=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #4ms;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired, run hung");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    clear_model();
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; ra = '0; rb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R2: every entry zero after reset
    for (int i = 0; i < 16; i++) cyc(1'b0, 5'd0, '0, 5'(i), 5'(i + 16), "R2");

    // R3 on port B (previous write), R5 on port A (same-cycle write)
    for (int i = 1; i < 32; i++)
      cyc(1'b1, 5'(i), {32'(i) * 32'h0101_0101 ^ 32'hA5A5_0000, 32'(i) * 32'h1020_4081},
          5'(i), 5'(i - 1), "R3 R5");
    cyc(1'b0, 5'd0, '0, 5'd31, 5'd30, "R3");

    // R7 on the zero-register instance, R8 on the plain instance
    cyc(1'b1, 5'd0, 64'hDEAD_BEEF_CAFE_F00D, 5'd0, 5'd0, "R7 R8");
    cyc(1'b0, 5'd0, '0, 5'd0, 5'd1, "R7 R8");

    // R4: idle write port with matching index is neither stored nor bypassed
    cyc(1'b0, 5'd5, 64'hFFFF_FFFF_FFFF_FFFF, 5'd5, 5'd5, "R4");
    cyc(1'b0, 5'd9, 64'h1234_5678_9ABC_DEF0, 5'd5, 5'd9, "R4");

    // R6: ports independent, bypass on one port or on both
    cyc(1'b1, 5'd7, 64'h0F0F_0F0F_7777_7777, 5'd9, 5'd7, "R5 R6");
    cyc(1'b1, 5'd12, 64'h5555_AAAA_3C3C_C3C3, 5'd12, 5'd12, "R5 R6");
    cyc(1'b0, 5'd0, '0, 5'd12, 5'd7, "R6");

    // R1: mixed traffic against the model
    for (int n = 0; n < 400; n++)
      cyc(1'($urandom), 5'($urandom), {$urandom, $urandom}, 5'($urandom), 5'($urandom), "R1");

    // R2: reset in mid-run clears everything again
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (2) @(posedge clk);
    clear_model();
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 16; i++) cyc(1'b0, 5'd0, '0, 5'(31 - i), 5'(i), "R2");

    @(negedge clk);
    #6;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule